// File: doc/BRIEF.md
# Multi-Bank Programmable Clock Divider

This block divides one fast source into three output banks of four lines each and one feedback line. Each bank picks its division ratio from a two-bit code of its own and a range bit that all banks share. Clearing the range bit doubles every ratio of banks A, B and C. The feedback line uses a plain four-entry ratio table that ignores the range bit. Every ratio is even, so each output toggles after half its ratio and has a 50% duty cycle.

The block has one synchronous clock, `clk`. The fast source and the slower reference clock arrive as single-cycle tick enables. The `pll_on` control chooses which tick stream advances the dividers, and setting it to 0 is the bypass mode. A line is "high impedance" whenever its enable output is low. Pulling `hold_n` low disables every output and clears all divider state, and the power-up reset `rst` does the same. The upper half of bank C can be inverted relative to its lower half.

Top module: `clkdiv_top`

## Requirements
- R1: With `range_hi`=1, bank A codes 0,1,2,3 divide the active tick stream by 4,6,8,12. With `range_hi`=0 they divide by 8,12,16,24.
- R2: With `range_hi`=1, bank B codes 0..3 divide by 4,6,8,10. With `range_hi`=0 they divide by 8,12,16,20.
- R3: With `range_hi`=1, bank C codes 0..3 divide by 2,4,6,8. With `range_hi`=0 they divide by 4,8,12,16.
- R4: Feedback code k (0..3) divides by 4*(k+1) whatever the value of `range_hi`.
- R5: While `inv_c`=1, `qc[3:2]` are the logical inverse of `qc[1:0]`. While `inv_c`=0, all four `qc` lines are equal.
- R6: When `pll_on`=1 only `vco_tick` advances the dividers. When `pll_on`=0 only `ref_tick` does.
- R7: Every output stays high for exactly half its ratio in ticks and then low for the same count. It never changes on a clock without a tick.
- R8: While `rst`=1 or `hold_n`=0 is sampled, every enable goes to 0 and every data line of `qa`, `qb`, `qc[1:0]` and `qfb` goes to 0 on the next clock. All divider counts restart.
- R9: After the clear is released, every bank starts at count zero from the same tick. Each output first rises after half its ratio in ticks, and all enables read 1 from the first clock without a clear.
- R10: A new code or range value is taken up by a bank only at that bank's next rising output edge, or during a clear. The half-period that is already running keeps its old length.

Ports are bit-indexed with lines 0..3 of each bank. Within bank C, the inverted lines are indices 2 and 3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high power-up reset |
| hold_n | input | 1 | Active-low master clear and output disable |
| vco_tick | input | 1 | One-cycle tick of the fast source |
| ref_tick | input | 1 | One-cycle tick of the reference clock |
| pll_on | input | 1 | 1: dividers use fast source, 0: bypass to reference |
| range_hi | input | 1 | Shared range bit; 0 doubles bank A/B/C ratios |
| sel_a | input | 2 | Bank A ratio code |
| sel_b | input | 2 | Bank B ratio code |
| sel_c | input | 2 | Bank C ratio code |
| sel_fb | input | 2 | Feedback ratio code |
| inv_c | input | 1 | Invert upper half of bank C |
| qa | output | 4 | Bank A data lines |
| oe_a | output | 4 | Bank A line enables |
| qb | output | 4 | Bank B data lines |
| oe_b | output | 4 | Bank B line enables |
| qc | output | 4 | Bank C data lines |
| oe_c | output | 4 | Bank C line enables |
| qfb | output | 1 | Feedback data line |
| oe_fb | output | 1 | Feedback line enable |

## Verification
Two events can fall on the same clock. The first is a code change arriving on the very tick where a bank's output rises, which tests whether the new ratio is latched there or one period later. The second is the release of `hold_n` on a cycle that carries a tick. The bench provokes both by changing selects every few cycles while ticks are dense, and by releasing clears at varying offsets from the tick pattern. A behavioural model updated every clock judges each cycle. Separate edge-interval counters confirm the half-period length once the selects are steady.

// File: rtl/clkdiv_pkg.sv
package clkdiv_pkg;

    localparam int NUM_BANKS = 4;
    localparam int CNT_W     = 5;

    typedef enum logic [1:0] {
        BANK_A  = 2'd0,
        BANK_B  = 2'd1,
        BANK_C  = 2'd2,
        BANK_FB = 2'd3
    } bank_e;

    typedef logic [CNT_W-1:0] half_t;

    typedef struct packed {
        logic       range_hi;
        logic [1:0] code;
    } sel_t;

    // Half of the division ratio, i.e. ticks per output level.
    function automatic half_t half_ratio(bank_e kind, sel_t s);
        half_t h;
        case (kind)
            BANK_A: begin
                case (s.code)
                    2'd0:    h = half_t'(2);
                    2'd1:    h = half_t'(3);
                    2'd2:    h = half_t'(4);
                    default: h = half_t'(6);
                endcase
            end
            BANK_B: h = half_t'({3'b000, s.code}) + half_t'(2);
            BANK_C: h = half_t'({3'b000, s.code}) + half_t'(1);
            default: h = (half_t'({3'b000, s.code}) + half_t'(1)) << 1;
        endcase
        if (kind != BANK_FB && !s.range_hi) begin
            h = h << 1;
        end
        return h;
    endfunction

endpackage

// File: rtl/clkdiv_bank.sv
module clkdiv_bank
    import clkdiv_pkg::*;
#(
    parameter bank_e KIND = BANK_A
) (
    input  logic clk,
    input  logic clr,
    input  logic tick,
    input  sel_t sel,
    output logic q
);

    half_t cnt;
    half_t half_q;
    half_t half_nxt;

    assign half_nxt = half_ratio(KIND, sel);

    always_ff @(posedge clk) begin
        if (clr) begin
            cnt    <= '0;
            q      <= 1'b0;
            half_q <= half_nxt;
        end else if (tick) begin
            if (cnt == half_q - half_t'(1)) begin
                cnt <= '0;
                q   <= ~q;
                if (!q) begin
                    half_q <= half_nxt;
                end
            end else begin
                cnt <= cnt + half_t'(1);
            end
        end
    end

    // R7: output holds on clocks without a tick
    a_r7_idle_hold: assert property (@(posedge clk) disable iff (clr)
        !tick |=> $stable(q));

    // R7: count stays inside the current half period
    a_r7_cnt_bound: assert property (@(posedge clk) disable iff (clr)
        cnt < half_q);

    // R10: ratio register moves only on a rising output edge
    a_r10_latch_on_rise: assert property (@(posedge clk) disable iff (clr)
        (!$past(clr) && !$stable(half_q)) |-> $rose(q));

endmodule

// File: rtl/clkdiv_outstage.sv
module clkdiv_outstage #(
    parameter int N         = 4,
    parameter bit INV_UPPER = 1'b0
) (
    input  logic         clk,
    input  logic         clr,
    input  logic         src_q,
    input  logic         inv,
    output logic [N-1:0] q,
    output logic [N-1:0] oe
);

    logic en_q;

    always_ff @(posedge clk) begin
        if (clr) begin
            en_q <= 1'b0;
        end else begin
            en_q <= 1'b1;
        end
    end

    generate
        for (genvar i = 0; i < N; i++) begin : g_line
            localparam bit FLIP = INV_UPPER && (i >= N / 2);
            assign q[i]  = src_q ^ (inv & FLIP);
            assign oe[i] = en_q;
        end
    endgenerate

endmodule

// File: rtl/clkdiv_top.sv
module clkdiv_top
    import clkdiv_pkg::*;
#(
    parameter int NUM_OUT = 4
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               hold_n,
    input  logic               vco_tick,
    input  logic               ref_tick,
    input  logic               pll_on,
    input  logic               range_hi,
    input  logic [1:0]         sel_a,
    input  logic [1:0]         sel_b,
    input  logic [1:0]         sel_c,
    input  logic [1:0]         sel_fb,
    input  logic               inv_c,
    output logic [NUM_OUT-1:0] qa,
    output logic [NUM_OUT-1:0] oe_a,
    output logic [NUM_OUT-1:0] qb,
    output logic [NUM_OUT-1:0] oe_b,
    output logic [NUM_OUT-1:0] qc,
    output logic [NUM_OUT-1:0] oe_c,
    output logic               qfb,
    output logic               oe_fb
);

    logic                 clr;
    logic                 tick;
    sel_t                 sel_v [NUM_BANKS];
    logic [NUM_BANKS-1:0] div_q;

    assign clr  = rst | ~hold_n;
    assign tick = pll_on ? vco_tick : ref_tick;

    assign sel_v[0] = '{range_hi: range_hi, code: sel_a};
    assign sel_v[1] = '{range_hi: range_hi, code: sel_b};
    assign sel_v[2] = '{range_hi: range_hi, code: sel_c};
    assign sel_v[3] = '{range_hi: range_hi, code: sel_fb};

    generate
        for (genvar g = 0; g < NUM_BANKS; g++) begin : g_bank
            clkdiv_bank #(.KIND(bank_e'(g))) u_bank (
                .clk  (clk),
                .clr  (clr),
                .tick (tick),
                .sel  (sel_v[g]),
                .q    (div_q[g])
            );
        end
    endgenerate

    clkdiv_outstage #(.N(NUM_OUT), .INV_UPPER(1'b0)) u_out_a (
        .clk(clk), .clr(clr), .src_q(div_q[0]), .inv(1'b0), .q(qa), .oe(oe_a)
    );

    clkdiv_outstage #(.N(NUM_OUT), .INV_UPPER(1'b0)) u_out_b (
        .clk(clk), .clr(clr), .src_q(div_q[1]), .inv(1'b0), .q(qb), .oe(oe_b)
    );

    clkdiv_outstage #(.N(NUM_OUT), .INV_UPPER(1'b1)) u_out_c (
        .clk(clk), .clr(clr), .src_q(div_q[2]), .inv(inv_c), .q(qc), .oe(oe_c)
    );

    clkdiv_outstage #(.N(1), .INV_UPPER(1'b0)) u_out_fb (
        .clk(clk), .clr(clr), .src_q(div_q[3]), .inv(1'b0), .q(qfb), .oe(oe_fb)
    );

    // R8: a sampled hold disables and zeroes every line on the next clock
    a_r8_hold_disables: assert property (@(posedge clk) disable iff (rst)
        !hold_n |=> (oe_a == '0 && oe_b == '0 && oe_c == '0 && !oe_fb &&
                     qa == '0 && qb == '0 && qc[0] == 1'b0 && !qfb));

    // R9: all banks start low together when hold is released
    a_r9_aligned_start: assert property (@(posedge clk) disable iff (rst)
        $rose(hold_n) |-> (!qa[0] && !qb[0] && !qc[0] && !qfb));

endmodule

// File: tb/sim_clkdiv_top.sv
module sim_clkdiv_top;

    logic clk = 1'b0;
    always #5 clk = ~clk;

    logic       rst = 1'b1, hold_n = 1'b0, vco_tick = 1'b0, ref_tick = 1'b0;
    logic       pll_on = 1'b1, range_hi = 1'b1, inv_c = 1'b0;
    logic [1:0] sel_a = 2'd0, sel_b = 2'd0, sel_c = 2'd0, sel_fb = 2'd0;
    logic [3:0] qa, oe_a, qb, oe_b, qc, oe_c;
    logic       qfb, oe_fb;

    clkdiv_top u0 (
        .clk(clk), .rst(rst), .hold_n(hold_n), .vco_tick(vco_tick), .ref_tick(ref_tick),
        .pll_on(pll_on), .range_hi(range_hi), .sel_a(sel_a), .sel_b(sel_b),
        .sel_c(sel_c), .sel_fb(sel_fb), .inv_c(inv_c),
        .qa(qa), .oe_a(oe_a), .qb(qb), .oe_b(oe_b), .qc(qc), .oe_c(oe_c),
        .qfb(qfb), .oe_fb(oe_fb)
    );

    int    errors = 0;
    int    checks = 0;
    string tag = "R8";
    bit    done = 1'b0;
    bit    meas_on = 1'b0;
    int    cyc = 0;

    // behavioural reference state
    int m_cnt [4];
    int m_half[4];
    bit m_q   [4];
    bit m_en = 1'b0;
    bit m_tk = 1'b0;

    // monitor state
    int tcnt [4];
    int nedge[4];
    bit pq   [4];

    function automatic int exp_ratio(int b, bit rng, int code);
        int r;
        case (b)
            0: r = (code == 3) ? 12 : 4 + 2 * code;
            1: r = 4 + 2 * code;
            2: r = 2 + 2 * code;
            default: r = 4 * (code + 1);
        endcase
        if (b != 3 && !rng) r = r * 2;
        return r;
    endfunction

    function automatic int code_of(int b);
        case (b)
            0: return int'(sel_a);
            1: return int'(sel_b);
            2: return int'(sel_c);
            default: return int'(sel_fb);
        endcase
    endfunction

    task automatic chk(bit ok, string req, int act, int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s [%s] t=%0t actual=%0h expected=%0h", req, tag, $time, act, exp);
        end
    endtask

    // tick streams: dense irregular source, reference every third cycle
    always @(posedge clk) begin
        #2;
        cyc++;
        vco_tick = ((cyc * 7) % 5) != 0;
        ref_tick = (cyc % 3) == 0;
    end

    // reference model, advanced on every clock
    always @(posedge clk) begin
        bit clr;
        clr  = rst || !hold_n;
        m_tk = pll_on ? vco_tick : ref_tick;
        for (int b = 0; b < 4; b++) begin
            if (clr) begin
                m_cnt[b]  = 0;
                m_q[b]    = 1'b0;
                m_half[b] = exp_ratio(b, range_hi, code_of(b)) / 2;
            end else if (m_tk) begin
                if (m_cnt[b] + 1 >= m_half[b]) begin
                    m_cnt[b] = 0;
                    m_q[b]   = !m_q[b];
                    if (m_q[b]) m_half[b] = exp_ratio(b, range_hi, code_of(b)) / 2;
                end else begin
                    m_cnt[b] = m_cnt[b] + 1;
                end
            end
        end
        m_en = !clr;
    end

    // compare every clock, away from the active edge
    always @(negedge clk) begin
        if (!done && cyc > 0) begin
            bit dq[4];
            chk(qa === {4{m_q[0]}}, "R1 bank A", qa, {4{m_q[0]}});
            chk(qb === {4{m_q[1]}}, "R2 bank B", qb, {4{m_q[1]}});
            chk(qc[1:0] === {2{m_q[2]}}, "R3 bank C", qc[1:0], {2{m_q[2]}});
            chk(qc[3:2] === {2{m_q[2] ^ inv_c}}, "R5 bank C upper", qc[3:2], {2{m_q[2] ^ inv_c}});
            chk(qfb === m_q[3], "R4 feedback", qfb, m_q[3]);
            chk({oe_a, oe_b, oe_c, oe_fb} === {13{m_en}}, "R8 enables",
                {oe_a, oe_b, oe_c, oe_fb}, {13{m_en}});
            dq[0] = qa[0]; dq[1] = qb[0]; dq[2] = qc[0]; dq[3] = qfb;
            for (int b = 0; b < 4; b++) begin
                if (meas_on && m_en) begin
                    if (m_tk) tcnt[b]++;
                    if (dq[b] !== pq[b]) begin
                        if (nedge[b] >= 2)
                            chk(tcnt[b] == exp_ratio(b, range_hi, code_of(b)) / 2,
                                $sformatf("R7 half period bank %0d", b),
                                tcnt[b], exp_ratio(b, range_hi, code_of(b)) / 2);
                        nedge[b]++;
                        tcnt[b] = 0;
                    end
                end else begin
                    tcnt[b]  = 0;
                    nedge[b] = 0;
                end
                pq[b] = dq[b];
            end
        end
    end

    task automatic step(int n);
        repeat (n) @(posedge clk);
        #2;
    endtask

    // watchdog
    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("watchdog expired");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        step(3);
        @(negedge clk);
        chk(oe_a == 4'h0 && oe_c == 4'h0 && qa == 4'h0, "R8 reset state", {oe_a, qa}, 0);
        step(0);
        @(posedge clk); #2;
        rst = 1'b0; hold_n = 1'b1;

        // R1 R2 R3 R4 R5 R7: every code, both ranges, inversion on and off
        tag = "R7";
        for (int rng = 1; rng >= 0; rng--) begin
            for (int s = 0; s < 4; s++) begin
                for (int iv = 0; iv < 2; iv++) begin
                    meas_on  = 1'b0;
                    range_hi = rng[0];
                    sel_a = s[1:0]; sel_b = 2'(3 - s); sel_c = s[1:0]; sel_fb = 2'(3 - s);
                    inv_c = iv[0];
                    step(1);
                    meas_on = 1'b1;
                    step(130);
                end
            end
        end

        // R6: bypass to the reference tick stream
        tag = "R6";
        pll_on = 1'b0;
        for (int s = 0; s < 4; s++) begin
            meas_on = 1'b0;
            range_hi = s[0];
            sel_a = s[1:0]; sel_b = s[1:0]; sel_c = 2'(3 - s); sel_fb = s[1:0];
            step(1);
            meas_on = 1'b1;
            step(260);
        end
        pll_on = 1'b1;
        meas_on = 1'b0;

        // R10: selects change at varying offsets while outputs run
        tag = "R10";
        for (int k = 0; k < 40; k++) begin
            sel_a  = 2'((k * 3) % 4);
            sel_b  = 2'((k * 5 + 1) % 4);
            sel_c  = 2'((k + 2) % 4);
            sel_fb = 2'(k % 4);
            range_hi = ((k / 5) % 2) == 0;
            step(3 + (k % 7));
        end

        // R9 R8: hold pulses and a reset pulse released at shifting offsets
        tag = "R9";
        for (int k = 0; k < 6; k++) begin
            hold_n = 1'b0;
            step(2 + k % 3);
            hold_n = 1'b1;
            @(negedge clk);
            chk(qa[0] == 1'b0 && qb[0] == 1'b0 && qc[0] == 1'b0 && qfb == 1'b0,
                "R9 aligned start", {qa[0], qb[0], qc[0], qfb}, 0);
            step(0);
            step(40 + 3 * k);
        end
        tag = "R8";
        rst = 1'b1;
        step(2);
        rst = 1'b0;
        step(60);

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule